// File: doc/BRIEF.md
# Tone Event Interrupt Queue

This block turns tone-detector state changes from a bank of echo-canceller channels into a queue of interrupt entries for a host. Any edge on a channel's detector level counts as an event: a rising edge (tone found) and a falling edge (tone gone) both count. Channels are paired into groups, and each pair has an A side and a B side. Each group has a power-up enable and separate A and B mask bits. These decide whether a channel's events are kept. Kept events wait in a per-channel pending bit. One event per cycle moves from there into a first-in first-out store, lowest channel number first.

The host reads through a single 8-bit register strobe. Each read returns the oldest entry, with a valid flag and the channel number, and removes it. A read of an empty queue returns zero. A level interrupt output stays high while anything is queued. A sticky overflow flag records that an event was lost because the store was full.

Top module: `tone_irq_queue`

## Requirements
- R1: After reset, `host_rdata` is 8'h00, `irq` is 0 and `ovf_flag` is 0.
- R2: A rising edge and a falling edge of `tone_lvl[c]` each add one entry carrying channel number c, provided the channel's group is powered and the channel is not masked.
- R3: Read word layout: bit 7 is the valid flag, bits 6 and 5 are always 0, and bits 4:0 hold the channel number. A valid entry for channel c therefore reads 8'h80 + c.
- R4: A pulse on `host_rd` loads the oldest entry into `host_rdata` and removes it from the queue, so the next read shows the next entry. A read while the queue is empty loads 8'h00.
- R5: Channel c belongs to group c/2. Even channels are side A and odd channels are side B. While `grp_mask_a[g]` is 1, events of channel 2g are discarded. While `grp_mask_b[g]` is 1, events of channel 2g+1 are discarded. Discarded events are never queued later.
- R6: While `grp_pwr_up[g]` is 0, edges on channels 2g and 2g+1 produce no entries. Setting the bit back to 1 does not by itself produce an entry.
- R7: When several channels change in the same cycle, their entries are queued in ascending channel order.
- R8: The queue holds 32 entries. An event that arrives while the queue is full is dropped, the stored entries keep their order, and `ovf_flag` becomes 1 and stays 1 until reset.
- R9: `irq` is 1 exactly while the queue holds at least one entry.
- R10: When a read and a new entry fall in the same cycle, both take effect. The read returns the old head, and the new entry is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tone_lvl | input | NUM_CH | Tone detector level per channel |
| grp_pwr_up | input | NUM_CH/2 | Per-group power-up enable |
| grp_mask_a | input | NUM_CH/2 | Per-group mask for the even (A) channel |
| grp_mask_b | input | NUM_CH/2 | Per-group mask for the odd (B) channel |
| host_rd | input | 1 | One-cycle read strobe of the queue register |
| host_rdata | output | 8 | Last read word: valid flag and channel number |
| irq | output | 1 | High while the queue is not empty |
| ovf_flag | output | 1 | Sticky flag for a dropped event |

## Verification
The properties assume that `host_rd` is a single-cycle pulse. They also assume that the mask and power-up inputs are held steady while an event moves from its pending bit into the queue, so an entry never reflects a mask change made in between. The bench keeps to this by driving every input on the falling edge. It changes masks and power only after the queue has drained, and it leaves several idle cycles after each change of tone levels before it reads. The same-cycle read and write case is set up by timing the read pulse against the known two-cycle path from a level change to a queue write.

// File: rtl/tiq_pkg.sv
package tiq_pkg;

  localparam int unsigned WORD_W = 8;
  localparam int unsigned CHN_FIELD_W = 5;

  // Host word: valid flag on top, two zero bits, then the channel field.
  function automatic logic [WORD_W-1:0] pack_word(input logic valid,
                                                  input logic [CHN_FIELD_W-1:0] chn);
    logic [WORD_W-1:0] w;
    w = '0;
    if (valid) begin
      w[WORD_W-1] = 1'b1;
      w[CHN_FIELD_W-1:0] = chn;
    end
    return w;
  endfunction

  // Group of a channel and which side of the pair it sits on.
  function automatic int unsigned group_of(input int unsigned chn);
    return chn / 2;
  endfunction

  function automatic logic on_side_b(input int unsigned chn);
    return (chn % 2) == 1;
  endfunction

  // Ring pointer advance, any depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/tiq_event_capture.sv
module tiq_event_capture
  import tiq_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tone_lvl,
  input  logic [NUM_CH/2-1:0] grp_pwr_up,
  input  logic [NUM_CH/2-1:0] grp_mask_a,
  input  logic [NUM_CH/2-1:0] grp_mask_b,
  input  logic [NUM_CH-1:0] grant,
  output logic [NUM_CH-1:0] evt,
  output logic [NUM_CH-1:0] pend
);

  logic [NUM_CH-1:0] prev_q;
  logic [NUM_CH-1:0] pend_q;
  logic [NUM_CH-1:0] allow;

  // Per-channel gate: group powered and this side not masked.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_gate
    localparam int unsigned GRP = group_of(c);
    if (on_side_b(c)) begin : g_b
      assign allow[c] = grp_pwr_up[GRP] & ~grp_mask_b[GRP];
    end else begin : g_a
      assign allow[c] = grp_pwr_up[GRP] & ~grp_mask_a[GRP];
    end
  end

  // Both edges count; prev_q always follows so changes while gated are absorbed.
  assign evt = (tone_lvl ^ prev_q) & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= tone_lvl;
      pend_q <= (pend_q & ~grant) | evt;
    end
  end

  assign pend = pend_q;

endmodule

// File: rtl/tiq_lowest_pick.sv
module tiq_lowest_pick #(
  parameter int unsigned N   = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N:0] below;

  assign below[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt[i]       = req[i] & ~below[i];
    assign below[i + 1] = below[i] | req[i];
  end

  assign any = below[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/tiq_fifo.sv
module tiq_fifo
  import tiq_pkg::*;
#(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 5,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_req,
  output logic [W-1:0]  rd_data,
  output logic          wr_ok,
  output logic          rd_ok,
  output logic          drop,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] cnt
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign rd_ok = rd_req & ~empty;
  assign wr_ok = wr_req & (~full | rd_ok);
  assign drop  = wr_req & ~wr_ok;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= PW'(ring_next(int'(wp_q), DEPTH));
      if (rd_ok) rp_q <= PW'(ring_next(int'(rp_q), DEPTH));
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rd_data = mem[rp_q];
  assign cnt     = cnt_q;

endmodule

// File: rtl/tone_irq_queue.sv
module tone_irq_queue
  import tiq_pkg::*;
#(
  parameter int unsigned NUM_CH     = 32,
  parameter int unsigned FIFO_DEPTH = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   tone_lvl,
  input  logic [NUM_CH/2-1:0] grp_pwr_up,
  input  logic [NUM_CH/2-1:0] grp_mask_a,
  input  logic [NUM_CH/2-1:0] grp_mask_b,
  input  logic                host_rd,
  output logic [7:0]          host_rdata,
  output logic                irq,
  output logic                ovf_flag
);

  localparam int unsigned ID_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1);

  // Named internal events, observed by the bound checker.
  logic [NUM_CH-1:0] evt, pend, grant;
  logic [ID_W-1:0]   grant_idx;
  logic              wr_req, wr_ok, rd_ok, drop, full, empty;
  logic [ID_W-1:0]   head_id;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [7:0]        rdata_q;
  logic              ovf_q;

  tiq_event_capture #(.NUM_CH(NUM_CH)) u_capture (
    .clk        (clk),
    .rst_n      (rst_n),
    .tone_lvl   (tone_lvl),
    .grp_pwr_up (grp_pwr_up),
    .grp_mask_a (grp_mask_a),
    .grp_mask_b (grp_mask_b),
    .grant      (grant),
    .evt        (evt),
    .pend       (pend)
  );

  tiq_lowest_pick #(.N(NUM_CH)) u_pick (
    .req (pend),
    .gnt (grant),
    .idx (grant_idx),
    .any (wr_req)
  );

  tiq_fifo #(.DEPTH(FIFO_DEPTH), .W(ID_W)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_data (grant_idx),
    .rd_req  (host_rd),
    .rd_data (head_id),
    .wr_ok   (wr_ok),
    .rd_ok   (rd_ok),
    .drop    (drop),
    .full    (full),
    .empty   (empty),
    .cnt     (fifo_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (host_rd) rdata_q <= pack_word(rd_ok, CHN_FIELD_W'(head_id));
      if (drop)    ovf_q   <= 1'b1;
    end
  end

  assign host_rdata = rdata_q;
  assign irq        = ~empty;
  assign ovf_flag   = ovf_q;

endmodule

// File: rtl/tone_irq_queue_chk.sv
module tone_irq_queue_chk #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_rd,
  input logic [7:0]    host_rdata,
  input logic          irq,
  input logic          ovf_flag,
  input logic          wr_req,
  input logic          wr_ok,
  input logic          full,
  input logic [CW-1:0] fifo_cnt
);

  assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rdata[6:5] == 2'b00);

  assert_empty_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rdata[7] |-> host_rdata[4:0] == 5'd0);

  assert_read_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fifo_cnt != '0) |=> host_rdata[7]);

  assert_pop_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fifo_cnt != '0 && !wr_ok) |=> fifo_cnt == $past(fifo_cnt) - CW'(1));

  assert_push_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fifo_cnt != '0 && wr_req) |=> fifo_cnt == $past(fifo_cnt));

  assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (fifo_cnt != '0));

  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full && !host_rd) |=> ovf_flag);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

endmodule

bind tone_irq_queue tone_irq_queue_chk #(.DEPTH(FIFO_DEPTH), .CW(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .irq        (irq),
  .ovf_flag   (ovf_flag),
  .wr_req     (wr_req),
  .wr_ok      (wr_ok),
  .full       (full),
  .fifo_cnt   (fifo_cnt)
);

// File: tb/test_tone_irq_queue.sv
module test_tone_irq_queue;

  localparam int NCH  = 32;
  localparam int NGRP = NCH / 2;
  localparam int DEP  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  tone = '0;
  logic [NGRP-1:0] pwr = '1;
  logic [NGRP-1:0] ma = '0;
  logic [NGRP-1:0] mb = '0;
  logic            rd = 1'b0;
  logic [7:0]      rdata;
  logic            irq, ovf;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tone_irq_queue #(.NUM_CH(NCH), .FIFO_DEPTH(DEP)) i_tone_irq_queue (
    .clk(clk), .rst_n(rst_n), .tone_lvl(tone), .grp_pwr_up(pwr),
    .grp_mask_a(ma), .grp_mask_b(mb), .host_rd(rd),
    .host_rdata(rdata), .irq(irq), .ovf_flag(ovf)
  );

  function automatic logic [7:0] word_of(input int ch);
    return 8'h80 + 8'(ch);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_read(input string req, input logic [7:0] exp);
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1", rdata, 8'h00);
    chk("R1", {7'd0, irq}, 8'h00);
    chk("R1", {7'd0, ovf}, 8'h00);
    // R4 empty read
    host_read("R4", 8'h00);

    // R2 R3 R4 R9 sweep over every channel, both edges
    for (int c = 0; c < NCH; c++) begin
      tone[c] = 1'b1;
      idle(4);
      chk("R9", {7'd0, irq}, 8'h01);
      host_read("R2", word_of(c));
      chk("R9", {7'd0, irq}, 8'h00);
      host_read("R4", 8'h00);
      tone[c] = 1'b0;
      idle(4);
      host_read("R3", word_of(c));
      host_read("R4", 8'h00);
    end

    // R5 masks per side
    for (int g = 0; g < NGRP; g++) begin
      ma[g] = 1'b1;
      tone[2*g] = 1'b1; tone[2*g+1] = 1'b1;
      idle(4);
      host_read("R5", word_of(2*g+1));
      host_read("R5", 8'h00);
      ma[g] = 1'b0; mb[g] = 1'b1;
      idle(1);
      tone[2*g] = 1'b0; tone[2*g+1] = 1'b0;
      idle(4);
      host_read("R5", word_of(2*g));
      host_read("R5", 8'h00);
      mb[g] = 1'b0;
    end

    // R6 power down
    for (int g = 0; g < NGRP; g++) begin
      pwr[g] = 1'b0;
      idle(1);
      tone[2*g+1] = 1'b1;
      idle(4);
      host_read("R6", 8'h00);
      pwr[g] = 1'b1;
      idle(4);
      host_read("R6", 8'h00);
      tone[2*g+1] = 1'b0;
      idle(4);
      host_read("R6", word_of(2*g+1));
      host_read("R6", 8'h00);
    end

    // R7 all channels at once, ascending order
    tone = '1;
    idle(45);
    chk("R8", {7'd0, ovf}, 8'h00);
    for (int i = 0; i < NCH; i++) host_read("R7", word_of(i));
    host_read("R7", 8'h00);

    // R8 fill, then overflow with a second burst
    tone = '0;
    idle(45);
    chk("R8", {7'd0, ovf}, 8'h00);
    tone = '1;
    idle(45);
    chk("R8", {7'd0, ovf}, 8'h01);
    chk("R9", {7'd0, irq}, 8'h01);
    for (int i = 0; i < DEP; i++) host_read("R8", word_of(i));
    host_read("R8", 8'h00);
    chk("R8", {7'd0, ovf}, 8'h01);

    // reset again clears the sticky flag
    tone = '0;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk("R1", {7'd0, ovf}, 8'h00);
    chk("R1", rdata, 8'h00);

    // R10 read and write in the same cycle
    tone[3] = 1'b1;
    idle(5);
    tone[9] = 1'b1; tone[10] = 1'b1;
    @(negedge clk) rd = 1'b1;   // pend set on the edge before this point
    @(negedge clk) rd = 1'b0;   // pop of 3 and write of 9 on the same edge
    chk("R10", rdata, word_of(3));
    idle(3);
    host_read("R10", word_of(9));
    host_read("R10", word_of(10));
    host_read("R10", 8'h00);

    finish_run();
  end

endmodule